// File: doc/BRIEF.md
# Plus/Minus-Two Arithmetic Unit

This block moves an N-bit operand up or down by exactly two in one pass of combinational logic. A single select input chooses the direction. The core is an ordinary ripple-carry adder/subtracter whose second operand is the constant two. When the unit subtracts, that constant is complemented and the select is fed in as the carry-in, so subtraction becomes two's-complement addition.

The same carry chain drives two overflow flags. The first flag reports a wrap of the result when the operand is read as an unsigned number. The second flag reports a wrap when the operand is read as a two's-complement signed number. A caller can therefore use the unit for either number system and consult whichever flag applies.

A parameter picks how the constant operand is built. It can be a row of XOR gates between the constant and the select. It can also be the reduced form, in which every bit is simply the select or its inverse. Both forms must give identical outputs. The width defaults to 5 and scales to 32 or 64 bits.

Top module: `plus_minus_two`

## Requirements
- R1: With `dec_sel` = 0 the `result` equals `op_a` + 2 modulo 2^WIDTH.
- R2: With `dec_sel` = 1 the `result` equals `op_a` − 2 modulo 2^WIDTH.
- R3: `result[0]` always equals `op_a[0]`, in both directions.
- R4: With `dec_sel` = 0, `uov` is 1 exactly when unsigned `op_a` ≥ 2^WIDTH − 2, which is the case where the sum wraps past the top.
- R5: With `dec_sel` = 1, `uov` is 1 exactly when unsigned `op_a` < 2, which is the case where the difference borrows below zero.
- R6: With `dec_sel` = 0, `sov` is 1 exactly when signed `op_a` is 2^(WIDTH−1) − 2 or 2^(WIDTH−1) − 1.
- R7: With `dec_sel` = 1, `sov` is 1 exactly when signed `op_a` is −2^(WIDTH−1) or −2^(WIDTH−1) + 1.
- R8: The two constant-operand variants, XOR gates (`BGEN_XOR`) and reduced wiring (`BGEN_WIRED`), give identical `result`, `uov` and `sov` for every input.
- R9: The same behaviour holds at WIDTH = 32, including the wrap corners at both ends of the unsigned range and the signed range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | Operand to be moved by two |
| dec_sel | input | 1 | 0 selects +2, 1 selects −2 |
| result | output | WIDTH | Operand plus or minus two, truncated to WIDTH |
| uov | output | 1 | Overflow when the operand is read as unsigned |
| sov | output | 1 | Overflow when the operand is read as two's-complement signed |

## Verification
The embedded checks assume that `op_a` and `dec_sel` are driven to known 0/1 values. They also assume the inputs are held stable long enough for the carry chain to settle before anyone reads the outputs. The bench meets both assumptions. It changes the inputs only just after a rising clock edge and reads the outputs at the following falling edge, and it never leaves an input undriven. Every 5-bit operand is applied in both directions to both constant-operand variants. The 32-bit instance is driven only at the values around the unsigned and signed wrap points and at ordinary mid-range values.

// File: rtl/pm2_pkg.sv
// Package for the plus/minus-two unit.
// Holds the choice of how the constant operand is built, plus a helper
// that yields the constant two at any width. Assumes WIDTH >= 3.
package pm2_pkg;

    // How the second adder operand is formed from the direction select.
    typedef enum logic {
        BGEN_WIRED = 1'b0,  // reduced form: each bit is the select or its inverse
        BGEN_XOR   = 1'b1   // explicit XOR of the constant with the select
    } pm2_bgen_e;

    // Step magnitude applied by the unit.
    localparam int unsigned STEP_MAGNITUDE = 2;

endpackage

// File: rtl/pm2_operand_gen.sv
// Builds the second adder operand for the plus/minus-two unit.
// For +2 it yields the zero-extended constant 0...010. For -2 it yields
// the one's complement of that constant (the carry-in completes the
// negation). The BGEN parameter selects XOR gates or the reduced wiring.
// Assumes WIDTH >= 3.
module pm2_operand_gen #(
    parameter int unsigned       WIDTH = 5,
    parameter pm2_pkg::pm2_bgen_e BGEN  = pm2_pkg::BGEN_WIRED
) (
    input  logic             dec_sel,
    output logic [WIDTH-1:0] b_opnd
);

    localparam logic [WIDTH-1:0] STEP_CONST = WIDTH'(pm2_pkg::STEP_MAGNITUDE);
    localparam int unsigned      HIGH_BITS  = WIDTH - 2;

    generate
        if (BGEN == pm2_pkg::BGEN_XOR) begin : g_xor_form
            // Explicit controlled inversion of the constant operand.
            always_comb begin
                b_opnd = STEP_CONST ^ {WIDTH{dec_sel}};
            end
        end else begin : g_wired_form
            // Reduced form: bit 1 is the inverted select, all others copy it.
            always_comb begin
                b_opnd = {{HIGH_BITS{dec_sel}}, ~dec_sel, dec_sel};
            end
        end
    endgenerate

endmodule

// File: rtl/pm2_full_adder.sv
// One-bit full adder cell used as a stage of the ripple chain.
// Purely combinational; has no assumptions beyond known inputs.
module pm2_full_adder (
    input  logic a_bit,
    input  logic b_bit,
    input  logic c_in,
    output logic s_bit,
    output logic c_out
);

    // Sum and majority carry of the three inputs.
    always_comb begin
        s_bit = a_bit ^ b_bit ^ c_in;
        c_out = (a_bit & b_bit) | (a_bit & c_in) | (b_bit & c_in);
    end

endmodule

// File: rtl/pm2_ripple_chain.sv
// WIDTH-bit ripple-carry adder made from full adder cells.
// Exposes the carry into and out of the most significant stage so the
// overflow logic can use them. Assumes WIDTH >= 2.
module pm2_ripple_chain #(
    parameter int unsigned WIDTH = 5
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             msb_carry_in,
    output logic             msb_carry_out
);

    logic [WIDTH:0] carry;

    // Seed the chain with the external carry.
    always_comb begin
        carry[0] = carry_in;
    end

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_stage
            pm2_full_adder u_fa (
                .a_bit (a_in[i]),
                .b_bit (b_in[i]),
                .c_in  (carry[i]),
                .s_bit (sum_out[i]),
                .c_out (carry[i+1])
            );
        end
    endgenerate

    // Bring out the two carries around the top stage.
    always_comb begin
        msb_carry_in  = carry[WIDTH-1];
        msb_carry_out = carry[WIDTH];
    end

endmodule

// File: rtl/pm2_flag_logic.sv
// Derives the unsigned and signed overflow flags from the adder carries.
// Unsigned: the carry-out marks a wrap when adding. A missing carry-out
// marks a borrow when subtracting. Signed: the carries into and out of
// the top stage disagree.
module pm2_flag_logic (
    input  logic dec_sel,
    input  logic msb_carry_in,
    input  logic msb_carry_out,
    output logic uov,
    output logic sov
);

    // Overflow flag generation.
    always_comb begin
        uov = msb_carry_out ^ dec_sel;
        sov = msb_carry_in ^ msb_carry_out;
    end

endmodule

// File: rtl/plus_minus_two.sv
// Plus/minus-two unit: result = op_a +/- 2 (mod 2^WIDTH), with unsigned
// and signed overflow flags. Fully combinational, so there is no clock and
// no reset. Inputs must be known and settled before the outputs are used.
// Assumes WIDTH >= 3.
module plus_minus_two #(
    parameter int unsigned        WIDTH = 5,
    parameter pm2_pkg::pm2_bgen_e BGEN  = pm2_pkg::BGEN_WIRED
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic             dec_sel,
    output logic [WIDTH-1:0] result,
    output logic             uov,
    output logic             sov
);

    localparam logic [WIDTH-1:0] PLUS_TWO  = WIDTH'(pm2_pkg::STEP_MAGNITUDE);
    localparam logic [WIDTH-1:0] MINUS_TWO = WIDTH'(0) - PLUS_TWO;
    localparam logic [WIDTH-1:0] SIGN_MASK = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] b_opnd;
    logic             c_msb_in;
    logic             c_msb_out;

    pm2_operand_gen #(
        .WIDTH (WIDTH),
        .BGEN  (BGEN)
    ) u_opnd (
        .dec_sel (dec_sel),
        .b_opnd  (b_opnd)
    );

    pm2_ripple_chain #(
        .WIDTH (WIDTH)
    ) u_chain (
        .a_in          (op_a),
        .b_in          (b_opnd),
        .carry_in      (dec_sel),
        .sum_out       (result),
        .msb_carry_in  (c_msb_in),
        .msb_carry_out (c_msb_out)
    );

    pm2_flag_logic u_flags (
        .dec_sel       (dec_sel),
        .msb_carry_in  (c_msb_in),
        .msb_carry_out (c_msb_out),
        .uov           (uov),
        .sov           (sov)
    );

    // Output relations checked against the operand.
    always_comb begin
        // R1 and R2: the distance from operand to result is exactly +2 or -2.
        a_r1_r2_step: assert (WIDTH'(result - op_a) == (dec_sel ? MINUS_TWO : PLUS_TWO));
        // R3: the adder leaves the low bit untouched.
        a_r3_lsb_kept: assert (result[0] == op_a[0]);
        // R4 and R5: an unsigned wrap shows up as a result at the opposite end of the range.
        a_r4_r5_unsigned_wrap: assert (uov == (dec_sel ? (result >= MINUS_TWO) : (result < PLUS_TWO)));
        // R6 and R7: a signed overflow flips the sign against the direction of travel.
        a_r6_r7_signed_wrap: assert (!sov || (((op_a & SIGN_MASK) != 0) == dec_sel
                                              && ((result & SIGN_MASK) != 0) == !dec_sel));
    end

endmodule

// File: tb/test_plus_minus_two.sv
// Directed bench for the plus/minus-two unit. Each task applies one
// scenario and checks its own results against values computed here.
module test_plus_minus_two;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned NW = 5;
    localparam int unsigned WW = 32;

    logic clk;
    logic rst_n;
    int   n_checks;
    int   n_fails;

    logic [NW-1:0] a5;
    logic          d5;
    logic [NW-1:0] r5_w, r5_x;
    logic          u5_w, u5_x, s5_w, s5_x;

    logic [WW-1:0] a32;
    logic          d32;
    logic [WW-1:0] r32;
    logic          u32, s32;

    plus_minus_two #(.WIDTH(NW), .BGEN(pm2_pkg::BGEN_WIRED)) i_plus_minus_two (
        .op_a (a5), .dec_sel (d5), .result (r5_w), .uov (u5_w), .sov (s5_w)
    );

    plus_minus_two #(.WIDTH(NW), .BGEN(pm2_pkg::BGEN_XOR)) i_plus_minus_two_xor (
        .op_a (a5), .dec_sel (d5), .result (r5_x), .uov (u5_x), .sov (s5_x)
    );

    plus_minus_two #(.WIDTH(WW), .BGEN(pm2_pkg::BGEN_WIRED)) i_plus_minus_two_wide (
        .op_a (a32), .dec_sel (d32), .result (r32), .uov (u32), .sov (s32)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Record one comparison.
    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply 5-bit inputs after a rising edge; the caller reads at the falling edge.
    task automatic drive5(input int v, input logic d);
        @(posedge clk);
        a5 = NW'(v);
        d5 = d;
        @(negedge clk);
    endtask

    // Apply 32-bit inputs the same way.
    task automatic drive32(input logic [WW-1:0] v, input logic d);
        @(posedge clk);
        a32 = v;
        d32 = d;
        @(negedge clk);
    endtask

    // Outputs held during reset with zero inputs: 0 + 2 = 2, no flags.
    task automatic t_reset_state;
        @(negedge clk);
        check("R1 reset result", 64'(r5_w), 64'd2);
        check("R4 reset uov", 64'(u5_w), 64'd0);
        check("R6 reset sov", 64'(s5_w), 64'd0);
    endtask

    // Every 5-bit operand, adding two.
    task automatic t_add_sweep;
        for (int v = 0; v < 32; v++) begin
            drive5(v, 1'b0);
            check("R1 add result", 64'(r5_w), 64'((v + 2) % 32));
            check("R3 add lsb", 64'(r5_w[0]), 64'(v % 2));
            check("R4 add uov", 64'(u5_w), 64'(v >= 30));
            check("R6 add sov", 64'(s5_w), 64'(v == 14 || v == 15));
            check("R8 add variants", {r5_x, u5_x, s5_x}, {r5_w, u5_w, s5_w});
        end
    endtask

    // Every 5-bit operand, subtracting two.
    task automatic t_sub_sweep;
        for (int v = 0; v < 32; v++) begin
            drive5(v, 1'b1);
            check("R2 sub result", 64'(r5_w), 64'((v + 30) % 32));
            check("R3 sub lsb", 64'(r5_w[0]), 64'(v % 2));
            check("R5 sub uov", 64'(u5_w), 64'(v < 2));
            check("R7 sub sov", 64'(s5_w), 64'(v == 16 || v == 17));
            check("R8 sub variants", {r5_x, u5_x, s5_x}, {r5_w, u5_w, s5_w});
        end
    endtask

    // Wide instance at the wrap corners and at mid-range values.
    task automatic t_wide_corners;
        drive32(32'hFFFF_FFFE, 1'b0);
        check("R9 add top result", 64'(r32), 64'h0);
        check("R9 add top uov", 64'(u32), 64'd1);
        check("R9 add top sov", 64'(s32), 64'd0);
        drive32(32'h7FFF_FFFF, 1'b0);
        check("R9 add smax result", 64'(r32), 64'h8000_0001);
        check("R9 add smax sov", 64'(s32), 64'd1);
        check("R9 add smax uov", 64'(u32), 64'd0);
        drive32(32'h8000_0000, 1'b1);
        check("R9 sub smin result", 64'(r32), 64'h7FFF_FFFE);
        check("R9 sub smin sov", 64'(s32), 64'd1);
        check("R9 sub smin uov", 64'(u32), 64'd0);
        drive32(32'h0000_0001, 1'b1);
        check("R9 sub low result", 64'(r32), 64'hFFFF_FFFF);
        check("R9 sub low uov", 64'(u32), 64'd1);
        check("R9 sub low sov", 64'(s32), 64'd0);
        drive32(32'h1234_5679, 1'b1);
        check("R9 sub mid result", 64'(r32), 64'h1234_5677);
        check("R9 sub mid flags", {u32, s32}, 64'd0);
        drive32(32'h7FFF_FFFD, 1'b0);
        check("R9 add near smax result", 64'(r32), 64'h7FFF_FFFF);
        check("R9 add near smax flags", {u32, s32}, 64'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 100000);
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        n_checks = 0;
        n_fails  = 0;
        rst_n = 1'b0;
        a5  = '0;
        d5  = 1'b0;
        a32 = '0;
        d32 = 1'b0;
        t_reset_state();
        @(posedge clk);
        rst_n = 1'b1;
        t_add_sweep();
        t_sub_sweep();
        t_wide_corners();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule